// File: doc/BRIEF.md
# Timer interrupt flag and mask unit

This block stores the pending-event flags and the per-source enables for two timer/counters. It tracks three sources: timer 1 compare match A, timer 1 overflow and timer 0 overflow. Each timer supplies a one-cycle event pulse. The pulse latches a flag, and the flag stays set until software or the interrupt controller clears it.

Both registers sit on a small 8-bit I/O register bus. Reads are combinational from the address, and writes take effect on the clock edge. A flag is cleared by writing a one to its bit, or by the CPU acknowledging that flag's vector. The block combines the flags, the enables and a global interrupt-enable input into a single request, together with the vector number of the highest-priority pending source.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset both the flag register and the mask register read 0x00.
- R2: The flag register is decoded at I/O address 0x38 and the mask register at 0x39. Any other address reads 0x00, and a write to any other address changes neither register.
- R3: In both registers, bit 6 is timer 1 compare match A, bit 2 is timer 1 overflow and bit 1 is timer 0 overflow. Bits 7, 5, 4, 3 and 0 always read zero, and writing them has no effect.
- R4: A write to 0x39 loads bits 6, 2 and 1 of the write data into the corresponding enables.
- R5: An event pulse sets its flag at the next clock edge.
- R6: A write to 0x38 clears each flag whose data bit is one and leaves unchanged each flag whose data bit is zero.
- R7: An acknowledge clears only the flag whose vector equals the acknowledged vector number; all other flags keep their value.
- R8: When an event pulse and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R9: The request output is high only when some source has its flag, its enable and the global interrupt-enable input all at one.
- R10: Vector numbers are 3 for compare match A, 4 for timer 1 overflow and 5 for timer 0 overflow. With several sources requesting, the lowest vector number is presented. With no request the vector output is 0.
- R11: Register read data follows the address in the same cycle, and a write becomes visible in read data only after the clock edge on which the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_cmpa1 | input | 1 | Timer 1 compare match A pulse |
| ev_ovf1 | input | 1 | Timer 1 overflow pulse |
| ev_ovf0 | input | 1 | Timer 0 overflow pulse |
| gie | input | 1 | Global interrupt enable |
| io_addr | input | 6 | I/O register address |
| io_wdata | input | 8 | Write data |
| io_we | input | 1 | Write strobe |
| io_rdata | output | 8 | Read data, combinational from address |
| irq_ack | input | 1 | CPU acknowledges a vector this cycle |
| ack_vec | input | 3 | Vector number being acknowledged |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 3 | Vector of the highest-priority request, 0 when idle |

## Verification
The bench aims at the collisions. An event pulse on the same cycle as a write-one or an acknowledge to that flag checks that the set wins; a design that lets the clear win would drop the event silently. An acknowledge arrives while other flags are pending; a design that cleared everything would lose those interrupts. Further checks cover writes of all ones to reserved bits (which would read back non-zero if stored), accesses to neighbouring addresses, and the global enable dropping with flags pending. A long random phase compares the read data, request and vector against a behavioural model on every cycle, which exposes priority inversions and vector mix-ups.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NSRC   = 3;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int VEC_W  = 3;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 6'h38;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 6'h39;
  localparam int VEC_BASE = 3;

  // Source index 0 = compare A timer 1, 1 = overflow timer 1, 2 = overflow timer 0
  function automatic int src_bitpos(input int idx);
    case (idx)
      0:       return 6;
      1:       return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(input int idx);
    return VEC_W'(VEC_BASE + idx);
  endfunction

  function automatic logic [DATA_W-1:0] pack_reg(input logic [NSRC-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) r[src_bitpos(i)] = v[i];
    return r;
  endfunction

  function automatic logic [NSRC-1:0] unpack_reg(input logic [DATA_W-1:0] d);
    logic [NSRC-1:0] v;
    for (int i = 0; i < NSRC; i++) v[i] = d[src_bitpos(i)];
    return v;
  endfunction
endpackage

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  ev,
  input  logic [NSRC-1:0]  wr_clr,
  input  logic             ack,
  input  logic [VEC_W-1:0] ack_vec,
  output logic [NSRC-1:0]  flag_q
);
  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    logic ack_hit;
    assign ack_hit = ack && (ack_vec == src_vector(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   flag_q[g] <= 1'b0;
      else if (ev[g])               flag_q[g] <= 1'b1;
      else if (wr_clr[g] || ack_hit) flag_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_irq_mask.sv
module tmr_irq_mask
  import tmr_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [NSRC-1:0] d,
  output logic [NSRC-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '0;
    else if (we) mask_q <= d;
  end
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb
  import tmr_irq_pkg::*;
(
  input  logic [NSRC-1:0]  flag_q,
  input  logic [NSRC-1:0]  mask_q,
  input  logic             gie,
  output logic [NSRC-1:0]  active,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  assign active = gie ? (flag_q & mask_q) : '0;
  assign req    = |active;

  // scan from the last source down so the lowest index is kept
  always_comb begin
    vec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[i]) vec = src_vector(i);
    end
  end
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cmpa1,
  input  logic              ev_ovf1,
  input  logic              ev_ovf0,
  input  logic              gie,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_we,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              irq_ack,
  input  logic [VEC_W-1:0]  ack_vec,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  logic [NSRC-1:0] ev_vec;
  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] active;
  logic [NSRC-1:0] wr_clr;
  logic            sel_flag;
  logic            sel_mask;
  logic            mask_we;

  assign ev_vec   = {ev_ovf0, ev_ovf1, ev_cmpa1};
  assign sel_flag = (io_addr == ADDR_FLAG);
  assign sel_mask = (io_addr == ADDR_MASK);
  assign mask_we  = io_we && sel_mask;
  assign wr_clr   = (io_we && sel_flag) ? unpack_reg(io_wdata) : '0;

  tmr_irq_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      (ev_vec),
    .wr_clr  (wr_clr),
    .ack     (irq_ack),
    .ack_vec (ack_vec),
    .flag_q  (flag_q)
  );

  tmr_irq_mask u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (mask_we),
    .d      (unpack_reg(io_wdata)),
    .mask_q (mask_q)
  );

  tmr_irq_arb u_arb (
    .flag_q (flag_q),
    .mask_q (mask_q),
    .gie    (gie),
    .active (active),
    .req    (irq_req),
    .vec    (irq_vec)
  );

  always_comb begin
    if (sel_flag)      io_rdata = pack_reg(flag_q);
    else if (sel_mask) io_rdata = pack_reg(mask_q);
    else               io_rdata = '0;
  end
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk
  import tmr_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              gie,
  input logic              io_we,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W-1:0] io_rdata,
  input logic [NSRC-1:0]   ev_vec,
  input logic [NSRC-1:0]   flag_q,
  input logic [NSRC-1:0]   mask_q,
  input logic              irq_ack,
  input logic [VEC_W-1:0]  ack_vec,
  input logic              irq_req,
  input logic [VEC_W-1:0]  irq_vec
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rdata & 8'hB9) == 8'h00); // R3

  AST_NO_REQ_WITHOUT_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_req); // R9

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_vec != '0) |=> ((flag_q & $past(ev_vec)) == $past(ev_vec))); // R8

  AST_ACK_SPARES_OVF1: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && ack_vec == 3'd3 && flag_q[1] && !(io_we && io_addr == ADDR_FLAG)) |=> flag_q[1]); // R7

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec >= 3'd3 && irq_vec <= 3'd5)); // R10

  AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == 3'd0)); // R10

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_we && io_addr == ADDR_MASK) |=> $stable(mask_q)); // R4
endmodule

bind tmr_irq_unit tmr_irq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gie      (gie),
  .io_we    (io_we),
  .io_addr  (io_addr),
  .io_rdata (io_rdata),
  .ev_vec   (ev_vec),
  .flag_q   (flag_q),
  .mask_q   (mask_q),
  .irq_ack  (irq_ack),
  .ack_vec  (ack_vec),
  .irq_req  (irq_req),
  .irq_vec  (irq_vec)
);

// File: tb/sim_tmr_irq_unit.sv
module sim_tmr_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_cmpa1 = 0, ev_ovf1 = 0, ev_ovf0 = 0, gie = 0;
  logic [5:0] io_addr = 6'h00;
  logic [7:0] io_wdata = 8'h00;
  logic       io_we = 0;
  logic [7:0] io_rdata;
  logic       irq_ack = 0;
  logic [2:0] ack_vec = 3'd0;
  logic       irq_req;
  logic [2:0] irq_vec;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural reference state
  bit m_ca, m_o1, m_o0;   // flags
  bit e_ca, e_o1, e_o0;   // enables

  always #5 clk = ~clk;

  tmr_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .ev_cmpa1(ev_cmpa1), .ev_ovf1(ev_ovf1), .ev_ovf0(ev_ovf0),
    .gie(gie), .io_addr(io_addr), .io_wdata(io_wdata), .io_we(io_we), .io_rdata(io_rdata),
    .irq_ack(irq_ack), .ack_vec(ack_vec), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  function automatic int model_read(input int a);
    if (a == 'h38) return (m_ca ? 64 : 0) + (m_o1 ? 4 : 0) + (m_o0 ? 2 : 0);
    if (a == 'h39) return (e_ca ? 64 : 0) + (e_o1 ? 4 : 0) + (e_o0 ? 2 : 0);
    return 0;
  endfunction

  function automatic int model_vec();
    if (!gie) return 0;
    if (m_ca && e_ca) return 3;
    if (m_o1 && e_o1) return 4;
    if (m_o0 && e_o0) return 5;
    return 0;
  endfunction

  // Inputs already applied; compare outputs now, then advance model over the edge.
  task automatic step();
    bit wf, wm, clr_ca, clr_o1, clr_o0;
    #1;
    check("rdata", io_rdata, model_read(io_addr));
    check("req", irq_req, model_vec() != 0);
    check("vec", irq_vec, model_vec());
    wf = io_we && io_addr == 6'h38;
    wm = io_we && io_addr == 6'h39;
    clr_ca = (wf && io_wdata[6]) || (irq_ack && ack_vec == 3);
    clr_o1 = (wf && io_wdata[2]) || (irq_ack && ack_vec == 4);
    clr_o0 = (wf && io_wdata[1]) || (irq_ack && ack_vec == 5);
    @(posedge clk);
    m_ca = ev_cmpa1 ? 1'b1 : (clr_ca ? 1'b0 : m_ca);
    m_o1 = ev_ovf1  ? 1'b1 : (clr_o1 ? 1'b0 : m_o1);
    m_o0 = ev_ovf0  ? 1'b1 : (clr_o0 ? 1'b0 : m_o0);
    if (wm) begin e_ca = io_wdata[6]; e_o1 = io_wdata[2]; e_o0 = io_wdata[1]; end
    @(negedge clk);
    cycles++;
  endtask

  task automatic idle();
    ev_cmpa1 = 0; ev_ovf1 = 0; ev_ovf0 = 0; io_we = 0; irq_ack = 0; ack_vec = 0;
  endtask

  task automatic wr(input int a, input int d);
    idle(); io_addr = 6'(a); io_wdata = 8'(d); io_we = 1; step(); idle();
  endtask

  task automatic rd(input int a);
    idle(); io_addr = 6'(a); step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    tag = "R1"; rd('h38); rd('h39);
    // R4 and R3: mask write of all ones keeps only bits 6,2,1
    tag = "R4"; wr('h39, 'hFF); rd('h39);
    tag = "R3"; wr('h39, 'hB9); rd('h39); wr('h39, 'h46);
    // R5: each event sets its flag
    tag = "R5"; idle(); ev_cmpa1 = 1; step(); idle(); ev_ovf1 = 1; step(); idle(); ev_ovf0 = 1; step(); rd('h38);
    // R2: other addresses read zero and writes there do nothing
    tag = "R2"; rd('h3A); rd('h37); rd('h00); wr('h3A, 'hFF); wr('h37, 'hFF); rd('h38); rd('h39);
    // R10: all three pending, gie on -> lowest vector first
    tag = "R10"; gie = 1; rd('h38);
    // R7: acknowledging 3 leaves 4 and 5 pending
    tag = "R7"; idle(); irq_ack = 1; ack_vec = 3; step(); rd('h38);
    idle(); irq_ack = 1; ack_vec = 5; step(); rd('h38);
    // R6: writing zero leaves flags, writing one clears
    tag = "R6"; ev_cmpa1 = 1; step(); wr('h38, 'h00); rd('h38); wr('h38, 'hB9); rd('h38); wr('h38, 'h04); rd('h38);
    // R8: event with write-one clear and with ack on the same cycle
    tag = "R8"; idle(); ev_ovf0 = 1; io_addr = 6'h38; io_wdata = 8'h02; io_we = 1; step(); rd('h38);
    idle(); ev_cmpa1 = 1; irq_ack = 1; ack_vec = 3; step(); rd('h38);
    // R9: gie and enables gate the request
    tag = "R9"; gie = 0; rd('h38); gie = 1; wr('h39, 'h00); rd('h38); wr('h39, 'h02); rd('h38);
    // R11: write visible only after the edge (step checks before edge)
    tag = "R11"; wr('h39, 'h44); rd('h39);
    // random phase: model compared every cycle
    tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      ev_cmpa1 = (r[3:0] == 0); ev_ovf1 = (r[7:4] == 0); ev_ovf0 = (r[11:8] == 0);
      gie = (r[14:12] != 0);
      io_addr = 6'h36 + 6'(r[17:15] % 5);
      io_wdata = 8'(r[25:18]);
      io_we = (r[28:26] == 0);
      irq_ack = irq_req && r[29];
      ack_vec = r[30] ? irq_vec : 3'(3 + (r[31] ? 1 : 2));
      step();
    end
    idle(); step();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule